// File: doc/BRIEF.md
# Fixed-OR Programmable Logic Array with Output Macrocells

The block is a small programmable sum-of-products engine. It has eight output slices fed by sixteen array variables. Each variable reaches the AND plane as two literal columns, one true and one complemented. Every slice owns eight product-term rows. Row 0 of a slice is the output-enable term. Rows 1 to 7 are summed by a fixed OR gate. The sum then passes through a per-slice polarity XOR, so a slice can build a function or its complement from at most seven product terms.

Six of the slices are bidirectional. Each of them takes its pin value back into the array as an input variable. The feedback value is the driven value while the slice drives its pin, and the external value while it does not. This lets one slice compute a helper term for another. The feedback passes through one register per pin, so a chain through a helper costs one clock. The three-state pin is modelled as three separate signals: the output value, the enable and the external input.

The full configuration is 2056 bits: the array bits followed by eight polarity bits. It is shifted in one bit per clock through a serial chain. A single load strobe then copies the chain into the active configuration in one step. Shifting alone never disturbs the running logic.

Top module: `fixed_or_array`

## Requirements
- R1: After synchronous active-low reset, every array bit of the active configuration is 1 and every polarity bit is 0. As a result every product term is 0, `pin_oe` is 8'h00 and `pin_out` is 8'h00.
- R2: While `cfg_shift_en` is 1, each clock shifts `cfg_bit` into the chain. The bit sent first ends at frame index 0 after 2056 shifts. A one-cycle `cfg_load` copies the chain into the active configuration. Shifting without a load leaves the outputs unchanged.
- R3: A product term is the AND of its selected literals. A row with no literal selected gives 1. A row that selects both columns of one variable gives 0.
- R4: A slice's value is the OR of its product-term rows 1 to 7, passed through the polarity XOR.
- R5: `pin_oe[o]` is 1 exactly while row 0 of slice o evaluates to 1. A constant-0 enable row makes the pin a pure input.
- R6: A set polarity bit inverts the slice's OR result, and a clear polarity bit passes it unchanged. With every OR row at 0, `pin_out[o]` equals the polarity bit.
- R7: For a bidirectional slice whose enable was 0 in the previous cycle, the array variable it feeds equals the `pin_in` bit sampled at the last clock edge.
- R8: For a bidirectional slice whose enable was 1 in the previous cycle, that variable equals the slice's `pin_out` value sampled at the last clock edge. Its `pin_in` bit is then ignored.
- R9: Layout. Variables 0 to 9 are `ded_in[9:0]`. Variable 10+k is the feedback of slice k+1 and of `pin_in[k]`, for k = 0 to 5, so slices 0 and 7 are output-only. Within a row, column 2v is the true literal of variable v and column 2v+1 its complement, and a bit set to 1 selects that literal. Frame index (8*o + t)*32 + c holds row t, column c of slice o. Frame index 2048 + o holds the polarity bit of slice o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_shift_en | input | 1 | Shift one configuration bit into the chain this cycle |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copy the chain into the active configuration |
| ded_in | input | 10 | Dedicated input pins, array variables 0 to 9 |
| pin_in | input | 6 | External value on the bidirectional pins of slices 1 to 6 |
| pin_out | output | 8 | Value each slice drives onto its pin |
| pin_oe | output | 8 | Driver enable of each slice's pin |

## Verification
The assertions check three things on every cycle. Each feedback register follows the driven value or the external pin, according to the enable of the previous cycle. The active configuration changes only on a load, and then takes the chain's contents. A row that selects a conflicting literal pair stays at 0, and a slice with all OR rows at 0 shows its polarity bit. Only the bench scenarios can show the rest. These are the bit ordering of the serial frame, the mapping of dedicated inputs and feedback pins to array variables, a multi-term OR combined with inversion, and the one-clock latency of a helper term through a feedback path.

// File: rtl/fo_pkg.sv
// Package fo_pkg
// Shared defaults and the pin-drive type of the fixed-OR array.
// Assumes: nothing beyond IEEE 1800-2017.
package fo_pkg;
    localparam int unsigned DEF_NVARS       = 16;
    localparam int unsigned DEF_NOUT        = 8;
    localparam int unsigned DEF_NTERMS      = 8;
    localparam int unsigned DEF_NBIDIR      = 6;
    localparam int unsigned DEF_FIRST_BIDIR = 1;

    // Value and enable that one slice presents at its pin.
    typedef struct packed {
        logic val;
        logic oe;
    } fo_drive_t;
endpackage

// File: rtl/fo_cfg_chain.sv
// Module fo_cfg_chain
// Serial shift chain plus an active configuration copy.
// The bit shifted in first ends at index 0.
// Assumes: the load and shift strobes are synchronous to clk. On a load,
// the active copy takes the chain as it was before that edge.
module fo_cfg_chain #(
    parameter int unsigned ARRAY_BITS = 2048,
    parameter int unsigned NPOL       = 8,
    localparam int unsigned TOTAL     = ARRAY_BITS + NPOL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             bit_i,
    input  logic             load_i,
    output logic [TOTAL-1:0] cfg_o
);
    logic [TOTAL-1:0] chain_q;

    // Shift a new bit in at the top of the chain.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else if (shift_i)
            chain_q <= {bit_i, chain_q[TOTAL-1:1]};
    end

    // Blank configuration on reset, otherwise copy the chain on load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_o <= {{NPOL{1'b0}}, {ARRAY_BITS{1'b1}}};
        else if (load_i)
            cfg_o <= chain_q;
    end

    AST_CFG_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load_i)) |-> (cfg_o == $past(chain_q))); // R2
    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_i)) |-> $stable(cfg_o)); // R2
endmodule

// File: rtl/fo_product_term.sv
// Module fo_product_term
// One AND row over the true and complemented literals of NVARS variables.
// Assumes: sel_i bit 2v selects the true literal of variable v, and bit
// 2v+1 selects its complement.
module fo_product_term #(
    parameter int unsigned NVARS = 16,
    localparam int unsigned COLS = 2 * NVARS
) (
    input  logic [NVARS-1:0] vars_i,
    input  logic [COLS-1:0]  sel_i,
    output logic             term_o
);
    logic [COLS-1:0] lits;
    logic            conflict;

    // Expand each variable into its true and complemented literal.
    always_comb begin
        for (int v = 0; v < NVARS; v++) begin
            lits[2*v]   = vars_i[v];
            lits[2*v+1] = ~vars_i[v];
        end
    end

    // Unselected literals act as 1, so an empty row yields 1.
    assign term_o = &(lits | ~sel_i);

    // Detect a row that selects both columns of one variable.
    always_comb begin
        conflict = 1'b0;
        for (int v = 0; v < NVARS; v++)
            conflict = conflict | (sel_i[2*v] & sel_i[2*v+1]);
    end

    always_comb begin
        if (conflict && !$isunknown(vars_i))
            AST_CONFLICT_KILLS: assert (term_o == 1'b0) else $error("conflict row not 0"); // R3
    end
endmodule

// File: rtl/fo_slice.sv
// Module fo_slice
// One output slice: NTERMS product rows. Row 0 is the output enable, and
// the remaining rows feed a fixed OR followed by a polarity XOR.
// Assumes: cfg_i holds row t at bits [t*COLS +: COLS].
module fo_slice
    import fo_pkg::*;
#(
    parameter int unsigned NVARS  = 16,
    parameter int unsigned NTERMS = 8,
    localparam int unsigned COLS  = 2 * NVARS
) (
    input  logic [NVARS-1:0]       vars_i,
    input  logic [NTERMS*COLS-1:0] cfg_i,
    input  logic                   pol_i,
    output fo_drive_t              drv_o
);
    logic [NTERMS-1:0] terms;
    logic              sum;

    for (genvar t = 0; t < NTERMS; t++) begin : g_row
        fo_product_term #(.NVARS(NVARS)) u_pt (
            .vars_i (vars_i),
            .sel_i  (cfg_i[t*COLS +: COLS]),
            .term_o (terms[t])
        );
    end

    // Fixed OR over every row except the enable row.
    assign sum       = |terms[NTERMS-1:1];
    assign drv_o.val = sum ^ pol_i;
    assign drv_o.oe  = terms[0];

    always_comb begin
        if (terms[NTERMS-1:1] == '0 && !$isunknown(pol_i))
            AST_POL_IDLE: assert (drv_o.val == pol_i) else $error("idle slice ignores polarity"); // R6
    end
endmodule

// File: rtl/fo_pin_feedback.sv
// Module fo_pin_feedback
// Feedback register of a bidirectional pin. It samples the driven value
// while the driver is on and the external value while it is off.
// Assumes: one clock of latency on the feedback path is acceptable, and
// it removes any combinational loop through the array.
module fo_pin_feedback (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_val_i,
    input  logic drive_oe_i,
    input  logic ext_i,
    output logic fb_o
);
    // Capture whichever source would appear on the pin this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fb_o <= 1'b0;
        else
            fb_o <= drive_oe_i ? drive_val_i : ext_i;
    end

    AST_FB_FOLLOWS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(drive_oe_i)) |-> (fb_o == $past(drive_val_i))); // R8
    AST_FB_FOLLOWS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(drive_oe_i)) |-> (fb_o == $past(ext_i))); // R7
endmodule

// File: rtl/fixed_or_array.sv
// Module fixed_or_array
// Programmable AND array with a fixed OR per output and serially loaded
// configuration. It has NOUT slices, NBIDIR of which feed their pins back
// into the array.
// Assumes: array variables are {feedback, dedicated inputs}. The
// bidirectional slices are FIRST_BIDIR .. FIRST_BIDIR+NBIDIR-1.
module fixed_or_array
    import fo_pkg::*;
#(
    parameter int unsigned NVARS       = DEF_NVARS,
    parameter int unsigned NOUT        = DEF_NOUT,
    parameter int unsigned NTERMS      = DEF_NTERMS,
    parameter int unsigned NBIDIR      = DEF_NBIDIR,
    parameter int unsigned FIRST_BIDIR = DEF_FIRST_BIDIR,
    localparam int unsigned NDED       = NVARS - NBIDIR,
    localparam int unsigned COLS       = 2 * NVARS,
    localparam int unsigned SLICE_BITS = NTERMS * COLS,
    localparam int unsigned ARRAY_BITS = NOUT * SLICE_BITS,
    localparam int unsigned CFG_BITS   = ARRAY_BITS + NOUT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_shift_en,
    input  logic              cfg_bit,
    input  logic              cfg_load,
    input  logic [NDED-1:0]   ded_in,
    input  logic [NBIDIR-1:0] pin_in,
    output logic [NOUT-1:0]   pin_out,
    output logic [NOUT-1:0]   pin_oe
);
    logic [CFG_BITS-1:0] cfg;
    logic [NBIDIR-1:0]   fb;
    logic [NVARS-1:0]    vars;
    fo_drive_t           drv [NOUT];

    fo_cfg_chain #(.ARRAY_BITS(ARRAY_BITS), .NPOL(NOUT)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (cfg_shift_en),
        .bit_i   (cfg_bit),
        .load_i  (cfg_load),
        .cfg_o   (cfg)
    );

    // Array variables: dedicated pins low, pin feedback high.
    assign vars = {fb, ded_in};

    for (genvar o = 0; o < NOUT; o++) begin : g_slice
        fo_slice #(.NVARS(NVARS), .NTERMS(NTERMS)) u_slice (
            .vars_i (vars),
            .cfg_i  (cfg[o*SLICE_BITS +: SLICE_BITS]),
            .pol_i  (cfg[ARRAY_BITS + o]),
            .drv_o  (drv[o])
        );

        assign pin_out[o] = drv[o].val;
        assign pin_oe[o]  = drv[o].oe;

        if (o >= FIRST_BIDIR && o < FIRST_BIDIR + NBIDIR) begin : g_bidir
            fo_pin_feedback u_fb (
                .clk         (clk),
                .rst_n       (rst_n),
                .drive_val_i (drv[o].val),
                .drive_oe_i  (drv[o].oe),
                .ext_i       (pin_in[o - FIRST_BIDIR]),
                .fb_o        (fb[o - FIRST_BIDIR])
            );
        end
    end
endmodule

// File: tb/fixed_or_array_bench.sv
module fixed_or_array_bench;
    localparam int NV   = 16;
    localparam int NT   = 8;
    localparam int COLS = 2 * NV;
    localparam int ARR  = 8 * NT * COLS;
    localparam int CFG  = ARR + 8;

    // {ded_in[9:0], pin_in[5:0], expected pin_out, expected pin_oe}
    localparam logic [31:0] VEC [6] = '{
        {10'h000, 6'h00, 8'h81, 8'h5D},
        {10'h3FF, 6'h00, 8'h7B, 8'hFD},
        {10'h004, 6'h3F, 8'h44, 8'h5D},
        {10'h001, 6'h10, 8'hC2, 8'h5D},
        {10'h018, 6'h3F, 8'h9D, 8'h7D},
        {10'h203, 6'h04, 8'h83, 8'hDD}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_shift_en = 1'b0;
    logic       cfg_bit = 1'b0;
    logic       cfg_load = 1'b0;
    logic [9:0] ded_in = '0;
    logic [5:0] pin_in = '0;
    logic [7:0] pin_out, pin_oe;
    logic [CFG-1:0] img;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fixed_or_array u_fixed_or_array (
        .clk(clk), .rst_n(rst_n), .cfg_shift_en(cfg_shift_en), .cfg_bit(cfg_bit),
        .cfg_load(cfg_load), .ded_in(ded_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_row(input int o, input int t);
        for (int c = 0; c < COLS; c++) img[(o*NT + t)*COLS + c] = 1'b0;
    endtask

    task automatic add_lit(input int o, input int t, input int v, input int inv);
        img[(o*NT + t)*COLS + 2*v + inv] = 1'b1;
    endtask

    task automatic shift_frame();
        for (int i = 0; i < CFG; i++) begin
            @(negedge clk);
            cfg_shift_en = 1'b1;
            cfg_bit = img[i];
        end
        @(negedge clk);
        cfg_shift_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 reset pin_out", pin_out, 8'h00);
        chk("R1 reset pin_oe", pin_oe, 8'h00);

        // Frame layout per R9: blank rows are all ones (conflicting, term 0).
        img = '0;
        img[ARR-1:0] = '1;
        clear_row(0, 0);
        clear_row(0, 1); add_lit(0, 1, 0, 0); add_lit(0, 1, 1, 0);
        clear_row(0, 2); add_lit(0, 2, 0, 1); add_lit(0, 2, 1, 1); add_lit(0, 2, 2, 1);
        clear_row(1, 0); add_lit(1, 0, 0, 0); add_lit(1, 0, 0, 1);
        clear_row(1, 1); add_lit(1, 1, 0, 0);
        clear_row(2, 0);
        clear_row(2, 1); add_lit(2, 1, 10, 0);
        clear_row(3, 0);
        clear_row(3, 1); add_lit(3, 1, 3, 0);
        clear_row(4, 0);
        clear_row(4, 1); add_lit(4, 1, 12, 0);
        clear_row(5, 0); add_lit(5, 0, 4, 0);
        clear_row(5, 1); add_lit(5, 1, 5, 0);
        clear_row(6, 0);
        clear_row(6, 1); add_lit(6, 1, 14, 0);
        clear_row(7, 0); add_lit(7, 0, 9, 0);
        clear_row(7, 1); add_lit(7, 1, 2, 0);
        img[ARR + 7] = 1'b1;

        ded_in = 10'h3FF;
        shift_frame();
        @(negedge clk);
        chk("R2 shift without load pin_out", pin_out, 8'h00);
        chk("R2 shift without load pin_oe", pin_oe, 8'h00);
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;

        for (int i = 0; i < 6; i++) begin
            ded_in = VEC[i][31:22];
            pin_in = VEC[i][21:16];
            repeat (2) @(negedge clk);
            chk($sformatf("R2 R4 R6 R7 R8 R9 vec%0d pin_out", i), pin_out, VEC[i][15:8]);
            chk($sformatf("R3 R5 vec%0d pin_oe", i), pin_oe, VEC[i][7:0]);
        end

        // R7: undriven pin of slice 1 reaches slice 2 one clock later.
        pin_in = 6'h05;
        #1;
        chk("R7 feedback before edge", {7'd0, pin_out[2]}, 8'h00);
        @(negedge clk);
        chk("R7 feedback after edge", {7'd0, pin_out[2]}, 8'h01);

        // R8: driven slice 3 feeds slice 4 one clock later, pin_in[2] ignored.
        ded_in = 10'h20B;
        #1;
        chk("R8 driven value before edge", {6'd0, pin_out[4], pin_out[3]}, 8'h01);
        @(negedge clk);
        chk("R8 driven value after edge", {6'd0, pin_out[4], pin_out[3]}, 8'h03);

        do_reset();
        chk("R1 re-reset pin_out", pin_out, 8'h00);
        chk("R1 re-reset pin_oe", pin_oe, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule